// File: doc/BRIEF.md
# Register and Immediate Data ALU with Destination Select

This block carries out the data operations of a small 8-bit controller whose instructions are 14 bits wide. For each accepted operation it takes the 6-bit operation field, the destination bit, the register operand, the working register W, an immediate byte (whose low bits also serve as a bit index) and the current carry. It returns the 8-bit result together with a write-enable for W or for the register, the new carry, half-carry and zero flags with an update enable for each, and a skip request for the next instruction. Register addressing, indirect access and the program counter belong to the surrounding core.

Operations enter on a valid/ready handshake and leave through one output register on a second valid/ready handshake. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its outcome appears on the outputs in the next cycle with `out_valid` high. It stays there, unchanged, until a rising edge where `out_ready` is high. `in_ready` is high whenever the output register is empty or being drained in the same cycle, so a consumer that keeps `out_ready` high gets one result per cycle. When the consumer holds `out_ready` low, back-pressure reaches the producer at once.

Top module: `alu_core`

## Requirements
- R1: Reset clears `out_valid`. An operation is taken on a rising edge with `in_valid` and `in_ready` high and shows on the outputs one cycle later with `out_valid` high. While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.
- R2: For two-operand register forms the destination bit picks the target: `in_dest`=0 raises `out_wr_w`, `in_dest`=1 raises `out_wr_reg`. The two write-enables are never high together. A flag output whose enable is low reads 0.
- R3: ADD (op 011011) gives W+R and updates C (carry out of bit 7), HC (carry out of bit 3) and Z.
- R4: SUB (op 011100) gives R+~W+1 and updates C, HC and Z. C=1 means no borrow, and HC=1 means no borrow out of the low nibble.
- R5: INC (op 011001) gives R+1 and DEC (op 011101) gives R-1. Both update Z only and follow the destination bit.
- R6: INC-skip (op 011010) and DEC-skip (op 011110) give R+1 and R-1, update no flag, and raise `out_skip` when the result is zero.
- R7: AND, OR and XOR with the register (ops 010010, 010011, 010100) and complement of R (op 011111) follow the destination bit. AND, OR and XOR with the immediate (ops 110100, 110101, 110110) always write W. All of them update Z only.
- R8: Rotate right (op 010110) puts the old carry in bit 7 and bit 0 into C. Rotate left (op 010101) puts the old carry in bit 0 and bit 7 into C. Both update C only.
- R9: Nibble swap (op 010111) exchanges bits 7..4 with bits 3..0, follows the destination bit, and updates no flag.
- R10: Bit clear (op 0000xx) and bit set (op 0010xx) clear or set bit `in_imm[2:0]` of R and write the register. The low two op bits and `in_imm[7:3]` are ignored, and no flag is updated.
- R11: Bit test-skip-if-clear (op 0001xx) and bit test-skip-if-set (op 0011xx) raise `out_skip` when bit `in_imm[2:0]` of R is 0 or 1 respectively. They write nothing and update no flag.
- R12: Op 010000 with `in_dest`=1 clears W, and op 010001 with `in_dest`=0 clears the register; both set Z. Op 011000 moves R to the destination and updates Z. Op 010001 with `in_dest`=1 stores W into the register, and op 111010 loads the immediate into W; neither updates a flag.
- R13: Whenever Z is updated, it is 1 exactly when the 8-bit result is zero.
- R14: Op 010000 with `in_dest`=0, and any op not listed above, writes nothing, updates no flag and requests no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 6 | Operation field |
| in_dest | input | 1 | Destination bit: 0 W, 1 register |
| in_reg | input | 8 | Register operand R |
| in_w | input | 8 | Working register W |
| in_imm | input | 8 | Immediate byte; bits 2..0 are the bit index |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Result byte |
| out_wr_w | output | 1 | Write result to W |
| out_wr_reg | output | 1 | Write result to the register |
| out_c | output | 1 | New carry |
| out_c_we | output | 1 | Carry update enable |
| out_hc | output | 1 | New half carry |
| out_hc_we | output | 1 | Half-carry update enable |
| out_z | output | 1 | New zero flag |
| out_z_we | output | 1 | Zero update enable |
| out_skip | output | 1 | Skip the next instruction |

## Verification
A wrong decode of the operation field shows up in the cycle after acceptance. It appears as a write-enable raised for the wrong target, a flag enable set for an operation that must leave that flag alone, or a skip that is missing or spurious. A wrong adder input, such as an uncomplemented W or a missing carry-in, shows at the same point as an off-by-one result or an inverted borrow sense in C and HC. A fault in the output register or its ready logic shows only under back-pressure: a held result changes before `out_ready`, or an offered operation is lost or accepted twice. The stalled handshake sequence therefore checks the held values over several cycles, not only the first one.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    K_NONE, K_ADD, K_SUB, K_INC, K_DEC, K_INCSZ, K_DECSZ,
    K_AND, K_IOR, K_XOR, K_ANDI, K_IORI, K_XORI, K_COM,
    K_RR, K_RL, K_SWAP, K_BCLR, K_BSET, K_BTC, K_BTS,
    K_CLR, K_MOVR, K_MOVW, K_LDI
  } alu_kind_e;

  typedef struct packed {
    alu_kind_e kind;
    logic      to_w;
    logic      to_reg;
    logic      upd_c;
    logic      upd_hc;
    logic      upd_z;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] op,
  input  logic           dest,
  output alu_ctrl_t      ctrl
);

  logic tw, tr;

  always_comb begin
    tw = ~dest;
    tr = dest;
    ctrl = '{kind: K_NONE, to_w: 1'b0, to_reg: 1'b0,
             upd_c: 1'b0, upd_hc: 1'b0, upd_z: 1'b0};
    casez (op)
      6'b0000??: begin ctrl.kind = K_BCLR; ctrl.to_reg = 1'b1; end
      6'b0010??: begin ctrl.kind = K_BSET; ctrl.to_reg = 1'b1; end
      6'b0001??: ctrl.kind = K_BTC;
      6'b0011??: ctrl.kind = K_BTS;
      6'b010000: if (dest) begin
        ctrl.kind = K_CLR; ctrl.to_w = 1'b1; ctrl.upd_z = 1'b1;
      end
      6'b010001: begin
        if (dest) ctrl.kind = K_MOVW;
        else begin ctrl.kind = K_CLR; ctrl.upd_z = 1'b1; end
        ctrl.to_reg = 1'b1;
      end
      6'b010010: begin ctrl.kind = K_AND;  ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b010011: begin ctrl.kind = K_IOR;  ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b010100: begin ctrl.kind = K_XOR;  ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b010101: begin ctrl.kind = K_RL;   ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_c = 1'b1; end
      6'b010110: begin ctrl.kind = K_RR;   ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_c = 1'b1; end
      6'b010111: begin ctrl.kind = K_SWAP; ctrl.to_w = tw; ctrl.to_reg = tr; end
      6'b011000: begin ctrl.kind = K_MOVR; ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b011001: begin ctrl.kind = K_INC;  ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b011010: begin ctrl.kind = K_INCSZ; ctrl.to_w = tw; ctrl.to_reg = tr; end
      6'b011011: begin
        ctrl.kind = K_ADD; ctrl.to_w = tw; ctrl.to_reg = tr;
        ctrl.upd_c = 1'b1; ctrl.upd_hc = 1'b1; ctrl.upd_z = 1'b1;
      end
      6'b011100: begin
        ctrl.kind = K_SUB; ctrl.to_w = tw; ctrl.to_reg = tr;
        ctrl.upd_c = 1'b1; ctrl.upd_hc = 1'b1; ctrl.upd_z = 1'b1;
      end
      6'b011101: begin ctrl.kind = K_DEC;   ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b011110: begin ctrl.kind = K_DECSZ; ctrl.to_w = tw; ctrl.to_reg = tr; end
      6'b011111: begin ctrl.kind = K_COM;   ctrl.to_w = tw; ctrl.to_reg = tr; ctrl.upd_z = 1'b1; end
      6'b110100: begin ctrl.kind = K_ANDI; ctrl.to_w = 1'b1; ctrl.upd_z = 1'b1; end
      6'b110101: begin ctrl.kind = K_IORI; ctrl.to_w = 1'b1; ctrl.upd_z = 1'b1; end
      6'b110110: begin ctrl.kind = K_XORI; ctrl.to_w = 1'b1; ctrl.upd_z = 1'b1; end
      6'b111010: begin ctrl.kind = K_LDI;  ctrl.to_w = 1'b1; end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_kind_e       kind,
  input  logic [DW-1:0]   r,
  input  logic [DW-1:0]   w,
  output logic [DW-1:0]   sum,
  output logic            cout,
  output logic            hcout
);

  localparam int HW = DW / 2;

  logic [DW-1:0] a, b;
  logic          cin;
  logic [DW:0]   full;
  logic [HW:0]   low;

  always_comb begin
    a   = r;
    b   = '0;
    cin = 1'b0;
    unique case (kind)
      K_ADD:           begin a = w; b = r; end
      K_SUB:           begin b = ~w; cin = 1'b1; end
      K_INC, K_INCSZ:  cin = 1'b1;
      K_DEC, K_DECSZ:  b = '1;
      default: ;
    endcase
  end

  assign full  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  assign low   = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
  assign sum   = full[DW-1:0];
  assign cout  = full[DW];
  assign hcout = low[HW];

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_kind_e     kind,
  input  logic [DW-1:0] r,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] imm,
  input  logic          carry,
  output logic [DW-1:0] res,
  output logic          rot_c,
  output logic          bit_skip
);

  localparam int HW = DW / 2;
  localparam int BW = $clog2(DW);

  logic [BW-1:0] idx;
  logic [DW-1:0] mask;

  assign idx  = imm[BW-1:0];
  assign mask = {{(DW-1){1'b0}}, 1'b1} << idx;

  always_comb begin
    res   = '0;
    rot_c = 1'b0;
    unique case (kind)
      K_AND:  res = r & w;
      K_IOR:  res = r | w;
      K_XOR:  res = r ^ w;
      K_ANDI: res = imm & w;
      K_IORI: res = imm | w;
      K_XORI: res = imm ^ w;
      K_COM:  res = ~r;
      K_RR:   begin res = {carry, r[DW-1:1]}; rot_c = r[0]; end
      K_RL:   begin res = {r[DW-2:0], carry}; rot_c = r[DW-1]; end
      K_SWAP: res = {r[HW-1:0], r[DW-1:HW]};
      K_BCLR: res = r & ~mask;
      K_BSET: res = r | mask;
      K_MOVR: res = r;
      K_MOVW: res = w;
      K_LDI:  res = imm;
      default: res = '0;
    endcase
  end

  always_comb begin
    bit_skip = 1'b0;
    if (kind == K_BTC) bit_skip = ~r[idx];
    else if (kind == K_BTS) bit_skip = r[idx];
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic           in_dest,
  input  logic [DW-1:0]  in_reg,
  input  logic [DW-1:0]  in_w,
  input  logic [DW-1:0]  in_imm,
  input  logic           in_carry,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_result,
  output logic           out_wr_w,
  output logic           out_wr_reg,
  output logic           out_c,
  output logic           out_c_we,
  output logic           out_hc,
  output logic           out_hc_we,
  output logic           out_z,
  output logic           out_z_we,
  output logic           out_skip
);

  alu_ctrl_t     ctrl;
  logic [DW-1:0] sum, lres, res;
  logic          a_c, a_hc, l_c, bskip;
  logic          is_arith, zero, skip_n, c_n;
  logic          fire;

  alu_decode #(.OPW(OPW)) u_dec (
    .op(in_op), .dest(in_dest), .ctrl(ctrl)
  );

  alu_arith #(.DW(DW)) u_arith (
    .kind(ctrl.kind), .r(in_reg), .w(in_w),
    .sum(sum), .cout(a_c), .hcout(a_hc)
  );

  alu_logic #(.DW(DW)) u_logic (
    .kind(ctrl.kind), .r(in_reg), .w(in_w), .imm(in_imm), .carry(in_carry),
    .res(lres), .rot_c(l_c), .bit_skip(bskip)
  );

  always_comb begin
    is_arith = (ctrl.kind inside {K_ADD, K_SUB, K_INC, K_DEC, K_INCSZ, K_DECSZ});
    res      = is_arith ? sum : lres;
    zero     = (res == '0);
    c_n      = (ctrl.kind inside {K_RR, K_RL}) ? l_c : a_c;
    skip_n   = bskip | ((ctrl.kind inside {K_INCSZ, K_DECSZ}) & zero);
  end

  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_w   <= 1'b0;
      out_wr_reg <= 1'b0;
      out_c      <= 1'b0;
      out_c_we   <= 1'b0;
      out_hc     <= 1'b0;
      out_hc_we  <= 1'b0;
      out_z      <= 1'b0;
      out_z_we   <= 1'b0;
      out_skip   <= 1'b0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= res;
      out_wr_w   <= ctrl.to_w;
      out_wr_reg <= ctrl.to_reg;
      out_c      <= ctrl.upd_c & c_n;
      out_c_we   <= ctrl.upd_c;
      out_hc     <= ctrl.upd_hc & a_hc;
      out_hc_we  <= ctrl.upd_hc;
      out_z      <= ctrl.upd_z & zero;
      out_z_we   <= ctrl.upd_z;
      out_skip   <= skip_n;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic          out_wr_w,
  input logic          out_wr_reg,
  input logic          out_c,
  input logic          out_c_we,
  input logic          out_hc_we,
  input logic          out_z,
  input logic          out_z_we,
  input logic          out_skip
);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_wr_w) && $stable(out_wr_reg) && $stable(out_c) &&
      $stable(out_z) && $stable(out_skip));

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r2_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_wr_w && out_wr_reg));

  a_r13_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_z_we |-> out_z == (out_result == '0));

  a_r6_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_skip |-> !out_c_we && !out_hc_we && !out_z_we);

  a_r3_hc_group: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hc_we |-> out_c_we && out_z_we);

endmodule

bind alu_core alu_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_wr_w(out_wr_w), .out_wr_reg(out_wr_reg), .out_c(out_c),
  .out_c_we(out_c_we), .out_hc_we(out_hc_we), .out_z(out_z),
  .out_z_we(out_z_we), .out_skip(out_skip)
);

// File: tb/sim_alu_core.sv
`timescale 1ns/1ps
module sim_alu_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_op = '0;
  logic       in_dest = 1'b0;
  logic [7:0] in_reg = '0, in_w = '0, in_imm = '0;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic       out_wr_w, out_wr_reg, out_c, out_c_we, out_hc, out_hc_we;
  logic       out_z, out_z_we, out_skip;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dest(in_dest), .in_reg(in_reg), .in_w(in_w),
    .in_imm(in_imm), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr_w(out_wr_w),
    .out_wr_reg(out_wr_reg), .out_c(out_c), .out_c_we(out_c_we),
    .out_hc(out_hc), .out_hc_we(out_hc_we), .out_z(out_z),
    .out_z_we(out_z_we), .out_skip(out_skip)
  );

  // Bundle: {result, wr_w, wr_reg, c_we, c, hc_we, hc, z_we, z, skip}
  function automatic logic [16:0] bundle();
    return {out_result, out_wr_w, out_wr_reg, out_c_we, out_c,
            out_hc_we, out_hc, out_z_we, out_z, out_skip};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one operation with out_ready high; sample the output a cycle later.
  task automatic run(string tag, logic [5:0] op, logic d, logic [7:0] r,
                     logic [7:0] w, logic [7:0] imm, logic cin,
                     logic [16:0] exp);
    @(negedge clk);
    in_op = op; in_dest = d; in_reg = r; in_w = w; in_imm = imm;
    in_carry = cin; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, {15'd0, bundle()}, {15'd0, exp});
  endtask

  // exp fields: res, ww, wr, cwe, c, hcwe, hc, zwe, z, skip
  function automatic logic [16:0] e(logic [7:0] res, logic ww, logic wr,
      logic cwe, logic c, logic hwe, logic hc, logic zwe, logic z, logic sk);
    return {res, ww, wr, cwe, c, hwe, hc, zwe, z, sk};
  endfunction

  task automatic t_reset();
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_add();
    run("R3 add wrap to reg", 6'b011011, 1'b1, 8'hC6, 8'h3A, 8'h00, 1'b0,
        e(8'h00, 0, 1, 1, 1, 1, 1, 1, 1, 0));
    run("R2 R3 add to W", 6'b011011, 1'b0, 8'h34, 8'h12, 8'h00, 1'b1,
        e(8'h46, 1, 0, 1, 0, 1, 0, 1, 0, 0));
  endtask

  task automatic t_sub();
    run("R4 sub no borrow", 6'b011100, 1'b1, 8'h50, 8'h20, 8'h00, 1'b0,
        e(8'h30, 0, 1, 1, 1, 1, 1, 1, 0, 0));
    run("R4 sub borrow", 6'b011100, 1'b0, 8'h20, 8'h50, 8'h00, 1'b1,
        e(8'hD0, 1, 0, 1, 0, 1, 1, 1, 0, 0));
    run("R4 sub nibble borrow", 6'b011100, 1'b0, 8'h10, 8'h01, 8'h00, 1'b0,
        e(8'h0F, 1, 0, 1, 1, 1, 0, 1, 0, 0));
    run("R4 sub equal", 6'b011100, 1'b1, 8'h77, 8'h77, 8'h00, 1'b0,
        e(8'h00, 0, 1, 1, 1, 1, 1, 1, 1, 0));
  endtask

  task automatic t_incdec();
    run("R5 inc wrap", 6'b011001, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b0,
        e(8'h00, 0, 1, 0, 0, 0, 0, 1, 1, 0));
    run("R5 dec to zero", 6'b011101, 1'b0, 8'h01, 8'h00, 8'h00, 1'b1,
        e(8'h00, 1, 0, 0, 0, 0, 0, 1, 1, 0));
    run("R5 dec wrap", 6'b011101, 1'b1, 8'h00, 8'h00, 8'h00, 1'b0,
        e(8'hFF, 0, 1, 0, 0, 0, 0, 1, 0, 0));
  endtask

  task automatic t_skipz();
    run("R6 incsz zero", 6'b011010, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b0,
        e(8'h00, 0, 1, 0, 0, 0, 0, 0, 0, 1));
    run("R6 incsz nonzero", 6'b011010, 1'b0, 8'h05, 8'h00, 8'h00, 1'b0,
        e(8'h06, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    run("R6 decsz zero", 6'b011110, 1'b1, 8'h01, 8'h00, 8'h00, 1'b0,
        e(8'h00, 0, 1, 0, 0, 0, 0, 0, 0, 1));
  endtask

  task automatic t_logic();
    run("R7 and reg zero", 6'b010010, 1'b1, 8'h0F, 8'hF0, 8'h00, 1'b0,
        e(8'h00, 0, 1, 0, 0, 0, 0, 1, 1, 0));
    run("R7 or reg", 6'b010011, 1'b0, 8'h0F, 8'hF0, 8'h00, 1'b0,
        e(8'hFF, 1, 0, 0, 0, 0, 0, 1, 0, 0));
    run("R7 xor reg zero", 6'b010100, 1'b0, 8'hAA, 8'hAA, 8'h00, 1'b0,
        e(8'h00, 1, 0, 0, 0, 0, 0, 1, 1, 0));
    run("R7 andi", 6'b110100, 1'b0, 8'h00, 8'hF0, 8'h3C, 1'b0,
        e(8'h30, 1, 0, 0, 0, 0, 0, 1, 0, 0));
    run("R7 iori ignores dest", 6'b110101, 1'b1, 8'h00, 8'h01, 8'h80, 1'b0,
        e(8'h81, 1, 0, 0, 0, 0, 0, 1, 0, 0));
    run("R7 xori", 6'b110110, 1'b0, 8'h00, 8'h0F, 8'hFF, 1'b0,
        e(8'hF0, 1, 0, 0, 0, 0, 0, 1, 0, 0));
    run("R7 com zero", 6'b011111, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1,
        e(8'h00, 0, 1, 0, 0, 0, 0, 1, 1, 0));
  endtask

  task automatic t_rotate();
    run("R8 rr carry in", 6'b010110, 1'b1, 8'h01, 8'h00, 8'h00, 1'b1,
        e(8'h80, 0, 1, 1, 1, 0, 0, 0, 0, 0));
    run("R8 rr carry clear", 6'b010110, 1'b0, 8'h82, 8'h00, 8'h00, 1'b0,
        e(8'h41, 1, 0, 1, 0, 0, 0, 0, 0, 0));
    run("R8 rl zero no z", 6'b010101, 1'b0, 8'h80, 8'h00, 8'h00, 1'b0,
        e(8'h00, 1, 0, 1, 1, 0, 0, 0, 0, 0));
    run("R8 rl carry in", 6'b010101, 1'b1, 8'h40, 8'h00, 8'h00, 1'b1,
        e(8'h81, 0, 1, 1, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_swap();
    run("R9 swap", 6'b010111, 1'b1, 8'h3C, 8'h00, 8'h00, 1'b1,
        e(8'hC3, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    run("R9 swap zero no z", 6'b010111, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0,
        e(8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_bits();
    run("R10 bclr idx3", 6'b000011, 1'b0, 8'hFF, 8'h00, 8'h0B, 1'b0,
        e(8'hF7, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    run("R10 bset idx7", 6'b001000, 1'b1, 8'h00, 8'h00, 8'hF7, 1'b0,
        e(8'h80, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    run("R11 btsc clear", 6'b000100, 1'b0, 8'hF7, 8'h00, 8'h03, 1'b0,
        e(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    run("R11 btsc set", 6'b000111, 1'b1, 8'hFF, 8'h00, 8'h03, 1'b0,
        e(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    run("R11 btss set", 6'b001101, 1'b0, 8'h04, 8'h00, 8'h02, 1'b0,
        e(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    run("R11 btss clear", 6'b001100, 1'b0, 8'hFE, 8'h00, 8'h00, 1'b0,
        e(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_moves();
    run("R12 clrw", 6'b010000, 1'b1, 8'h55, 8'h66, 8'h00, 1'b0,
        e(8'h00, 1, 0, 0, 0, 0, 0, 1, 1, 0));
    run("R12 clrr", 6'b010001, 1'b0, 8'h55, 8'h66, 8'h00, 1'b0,
        e(8'h00, 0, 1, 0, 0, 0, 0, 1, 1, 0));
    run("R12 stwr", 6'b010001, 1'b1, 8'h00, 8'h5A, 8'h00, 1'b0,
        e(8'h5A, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    run("R12 R13 ldr zero", 6'b011000, 1'b0, 8'h00, 8'h12, 8'h00, 1'b0,
        e(8'h00, 1, 0, 0, 0, 0, 0, 1, 1, 0));
    run("R12 ldr nonzero", 6'b011000, 1'b1, 8'h9C, 8'h12, 8'h00, 1'b0,
        e(8'h9C, 0, 1, 0, 0, 0, 0, 1, 0, 0));
    run("R12 ldwi", 6'b111010, 1'b1, 8'h00, 8'h00, 8'h77, 1'b0,
        e(8'h77, 1, 0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_none();
    run("R14 nop", 6'b010000, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1,
        e(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    run("R14 unlisted", 6'b111111, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1,
        e(8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 6'b111010; in_dest = 1'b0; in_imm = 8'hA5; in_valid = 1'b1;
    @(negedge clk);
    check("R1 stall first valid", {31'd0, out_valid}, 32'd1);
    check("R1 stall in_ready low", {31'd0, in_ready}, 32'd0);
    in_op = 6'b011001; in_dest = 1'b1; in_reg = 8'h3F;
    repeat (3) @(negedge clk);
    check("R1 stall held", {15'd0, bundle()},
          {15'd0, e(8'hA5, 1, 0, 0, 0, 0, 0, 0, 0, 0)});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second after drain", {15'd0, bundle()},
          {15'd0, e(8'h40, 0, 1, 0, 0, 0, 0, 1, 0, 0)});
    @(negedge clk);
    check("R1 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_incdec();
    t_skipz();
    t_logic();
    t_rotate();
    t_swap();
    t_bits();
    t_moves();
    t_none();
    t_stall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule